// File: doc/BRIEF.md
# Eight-Channel DMA Control and Status Register File

This block is the register file that sits between a processor-side register bus and eight independent DMA transfer engines. Software programs each channel's transfer mode, its direction and whether its completion raises the interrupt line. It then launches a channel by writing a start request. The block turns that request into a one-cycle start strobe for the engine, but only if the engine reports that it is idle.

In the other direction, the block shows each engine's live two-bit activity state in a status word. It turns the engines' completion and error pulses into sticky flags, which software clears by writing ones. A single interrupt output is raised while any enabled channel has its flag set.

The register bus is single-cycle. A request with `bus_sel` high and `bus_wr` high writes in that cycle. A request with `bus_sel` high and `bus_wr` low returns its data on `bus_rdata` after the next clock edge. Register offsets are byte addresses: 0x00 holds the channel modes, 0x04 is a general-purpose word, 0x08 holds the interrupt enables and the start requests, and 0x10 holds the flags and states. Offsets 0x0C and 0x14 read as zero.

Top module: `dmac_csr_block`

## Requirements
- R1: After reset, every register reads zero, `irq` is low, and `ch_start`, `ch_mode` and `ch_dir` are all zero.
- R2: At offset 0x00, channel ch owns bits [4ch+3:4ch]. Bits [1:0] of that slice are the mode (0 off, 1 scatter-gather, 2 single-shot) and bit 2 is the direction (1 = memory to device). Bit 3 of each slice is not stored and reads 0. After the write edge, `ch_mode[2ch+1:2ch]` and `ch_dir[ch]` show the written values.
- R3: Offset 0x04 is a 32-bit word that reads back exactly what was last written to it.
- R4: At offset 0x08, bits [7:0] are the per-channel interrupt enables, which read back as written. Bits [15:8] are start requests and always read back as 0.
- R5: Writing 1 to bit 8+ch of offset 0x08 while `ch_state[2ch+1:2ch]` is 0 raises `ch_start[ch]` for exactly the one cycle that follows the write.
- R6: A start request for a channel whose state is not 0 is ignored, and no strobe appears on `ch_start`.
- R7: At offset 0x10, bit ch is the interrupt flag and bit 8+ch is the error flag. Bits [17+2ch:16+2ch] are the live value of `ch_state[2ch+1:2ch]`, encoded 0 idle, 1 fetching a descriptor, 2 waiting, 3 moving data.
- R8: A `ch_done` pulse sets the channel's interrupt flag. A `ch_err` pulse sets both the error flag and the interrupt flag. Both flags stay set until software clears them.
- R9: A write to offset 0x10 clears each flag whose bit is 1 in the write data and leaves the other flags unchanged.
- R10: If a set pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R11: `irq` is high exactly while some channel has both its interrupt flag and its enable set.
- R12: Offsets 0x0C and 0x14, and any offset without a register, read as zero. Writes to them have no effect.
- R13: `bus_rdata` changes only in the cycle after a read request and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read request |
| ch_state | input | 16 | Two-bit activity state per channel |
| ch_done | input | 8 | Per-channel completion pulse |
| ch_err | input | 8 | Per-channel error pulse |
| ch_mode | output | 16 | Two-bit transfer mode per channel |
| ch_dir | output | 8 | Direction per channel |
| ch_start | output | 8 | One-cycle start strobe per channel |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default of eight channels. Every field in the packed words is therefore populated, and the highest channel's state lands in bits 31:30 of the status word, which exercises the top edge of every slice calculation. With all eight channels present, a single start write can request several channels at once while one of them is busy, so the idle gating of R6 is checked alongside live strobes on the other channels. The flag tests set a flag and clear it in the same cycle on one channel while other channels hold flags, which separates per-bit clearing from whole-word clearing.

// File: rtl/dmac_reg_pkg.sv
package dmac_reg_pkg;

    localparam int unsigned REG_AW = 5;
    localparam int unsigned REG_DW = 32;
    localparam int unsigned MAX_CH = 8;

    localparam logic [REG_AW-1:0] OFF_MODE     = 5'h00;
    localparam logic [REG_AW-1:0] OFF_AUX      = 5'h04;
    localparam logic [REG_AW-1:0] OFF_RUN      = 5'h08;
    localparam logic [REG_AW-1:0] OFF_RSVD     = 5'h0C;
    localparam logic [REG_AW-1:0] OFF_STAT     = 5'h10;
    localparam logic [REG_AW-1:0] OFF_STAT_AUX = 5'h14;

    localparam int unsigned ERR_BASE   = 8;
    localparam int unsigned START_BASE = 8;
    localparam int unsigned PHASE_BASE = 16;

    typedef enum logic [1:0] {
        CH_IDLE       = 2'd0,
        CH_DESC_FETCH = 2'd1,
        CH_WAIT       = 2'd2,
        CH_MOVE       = 2'd3
    } ch_phase_e;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_MODE = 3'd1,
        SEL_AUX  = 3'd2,
        SEL_RUN  = 3'd3,
        SEL_STAT = 3'd4
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [REG_AW-1:0] off);
        reg_sel_e kind;
        unique case (off)
            OFF_MODE:     kind = SEL_MODE;
            OFF_AUX:      kind = SEL_AUX;
            OFF_RUN:      kind = SEL_RUN;
            OFF_STAT:     kind = SEL_STAT;
            OFF_RSVD:     kind = SEL_NONE;
            OFF_STAT_AUX: kind = SEL_NONE;
            default:      kind = SEL_NONE;
        endcase
        return kind;
    endfunction

endpackage

// File: rtl/dmac_ctrl_regs.sv
module dmac_ctrl_regs
    import dmac_reg_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_mode,
    input  logic                  wr_aux,
    input  logic                  wr_run,
    input  logic [REG_DW-1:0]     wdata,
    input  logic [2*NUM_CH-1:0]   ch_state,
    output logic [2*NUM_CH-1:0]   mode_q,
    output logic [NUM_CH-1:0]     dir_q,
    output logic [REG_DW-1:0]     aux_q,
    output logic [NUM_CH-1:0]     irq_en_q,
    output logic [NUM_CH-1:0]     start_q
);

    localparam int unsigned SLICE_W = 4;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux_q <= '0;
        end else if (wr_aux) begin
            aux_q <= wdata;
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ch_phase_e phase;
        assign phase = ch_phase_e'(ch_state[2*i +: 2]);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_q[2*i +: 2] <= 2'b00;
                dir_q[i]         <= 1'b0;
            end else if (wr_mode) begin
                mode_q[2*i +: 2] <= wdata[SLICE_W*i +: 2];
                dir_q[i]         <= wdata[SLICE_W*i + 2];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irq_en_q[i] <= 1'b0;
            end else if (wr_run) begin
                irq_en_q[i] <= wdata[i];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_q[i] <= 1'b0;
            end else begin
                start_q[i] <= wr_run && wdata[START_BASE + i] && (phase == CH_IDLE);
            end
        end

        AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            start_q[i] |-> ($past(ch_state[2*i +: 2]) == CH_IDLE)); // R6
        AST_START_HAS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
            start_q[i] |-> $past(wr_run && wdata[START_BASE + i])); // R5
        AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_mode |=> $stable(mode_q[2*i +: 2])); // R2
    end

endmodule

// File: rtl/dmac_stat_flags.sv
module dmac_stat_flags #(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_done,
    input  logic [NUM_CH-1:0] ch_err,
    input  logic              clr_wr,
    input  logic [NUM_CH-1:0] clr_irq_bits,
    input  logic [NUM_CH-1:0] clr_err_bits,
    output logic [NUM_CH-1:0] irq_flag,
    output logic [NUM_CH-1:0] err_flag
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_flag
        logic set_irq;
        logic kill_irq;
        logic kill_err;

        assign set_irq  = ch_done[i] | ch_err[i];
        assign kill_irq = clr_wr & clr_irq_bits[i];
        assign kill_err = clr_wr & clr_err_bits[i];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irq_flag[i] <= 1'b0;
            end else if (set_irq) begin
                irq_flag[i] <= 1'b1;
            end else if (kill_irq) begin
                irq_flag[i] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                err_flag[i] <= 1'b0;
            end else if (ch_err[i]) begin
                err_flag[i] <= 1'b1;
            end else if (kill_err) begin
                err_flag[i] <= 1'b0;
            end
        end

        AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_done[i] || ch_err[i]) |=> irq_flag[i]); // R10
        AST_ERR_MARKS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
            ch_err[i] |=> (err_flag[i] && irq_flag[i])); // R8
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_flag[i] && !clr_wr) |=> irq_flag[i]); // R8
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && clr_irq_bits[i] && !ch_done[i] && !ch_err[i]) |=> !irq_flag[i]); // R9
    end

endmodule

// File: rtl/dmac_csr_block.sv
module dmac_csr_block
    import dmac_reg_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [4:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [2*NUM_CH-1:0] ch_state,
    input  logic [NUM_CH-1:0]   ch_done,
    input  logic [NUM_CH-1:0]   ch_err,
    output logic [2*NUM_CH-1:0] ch_mode,
    output logic [NUM_CH-1:0]   ch_dir,
    output logic [NUM_CH-1:0]   ch_start,
    output logic                irq
);

    localparam int unsigned SLICE_W = 4;

    reg_sel_e              kind;
    logic                  wr_hit;
    logic                  rd_hit;
    logic [REG_DW-1:0]     aux_q;
    logic [NUM_CH-1:0]     irq_en_q;
    logic [NUM_CH-1:0]     irq_flag;
    logic [NUM_CH-1:0]     err_flag;
    logic [REG_DW-1:0]     rd_next;
    logic [REG_DW-1:0]     rdata_q;

    assign kind   = decode_offset(bus_addr);
    assign wr_hit = bus_sel &  bus_wr;
    assign rd_hit = bus_sel & ~bus_wr;

    dmac_ctrl_regs #(.NUM_CH(NUM_CH)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_mode  (wr_hit && kind == SEL_MODE),
        .wr_aux   (wr_hit && kind == SEL_AUX),
        .wr_run   (wr_hit && kind == SEL_RUN),
        .wdata    (bus_wdata),
        .ch_state (ch_state),
        .mode_q   (ch_mode),
        .dir_q    (ch_dir),
        .aux_q    (aux_q),
        .irq_en_q (irq_en_q),
        .start_q  (ch_start)
    );

    dmac_stat_flags #(.NUM_CH(NUM_CH)) flags_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ch_done      (ch_done),
        .ch_err       (ch_err),
        .clr_wr       (wr_hit && kind == SEL_STAT),
        .clr_irq_bits (bus_wdata[NUM_CH-1:0]),
        .clr_err_bits (bus_wdata[ERR_BASE +: NUM_CH]),
        .irq_flag     (irq_flag),
        .err_flag     (err_flag)
    );

    always_comb begin
        rd_next = '0;
        unique case (kind)
            SEL_MODE: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    rd_next[SLICE_W*i +: 3] = {ch_dir[i], ch_mode[2*i +: 2]};
                end
            end
            SEL_AUX: rd_next = aux_q;
            SEL_RUN: rd_next[NUM_CH-1:0] = irq_en_q;
            SEL_STAT: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    rd_next[i]                 = irq_flag[i];
                    rd_next[ERR_BASE + i]      = err_flag[i];
                    rd_next[PHASE_BASE + 2*i +: 2] = ch_state[2*i +: 2];
                end
            end
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_hit) begin
            rdata_q <= rd_next;
        end
    end

    assign bus_rdata = rdata_q;
    assign irq       = |(irq_flag & irq_en_q);

    AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && (bus_addr == OFF_RSVD || bus_addr == OFF_STAT_AUX)) |=> (bus_rdata == '0)); // R12
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> $stable(bus_rdata)); // R13
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_flag != '0)); // R11

endmodule

// File: tb/dmac_csr_block_tb.sv
module dmac_csr_block_tb_top;

    localparam int unsigned NCH  = 8;
    localparam int unsigned NVEC = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_sel = 1'b0;
    logic             bus_wr = 1'b0;
    logic [4:0]       bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [2*NCH-1:0] ch_state = '0;
    logic [NCH-1:0]   ch_done = '0;
    logic [NCH-1:0]   ch_err = '0;
    logic [2*NCH-1:0] ch_mode;
    logic [NCH-1:0]   ch_dir;
    logic [NCH-1:0]   ch_start;
    logic             irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dmac_csr_block #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_state(ch_state), .ch_done(ch_done), .ch_err(ch_err),
        .ch_mode(ch_mode), .ch_dir(ch_dir), .ch_start(ch_start), .irq(irq)
    );

    // {is_write, offset, write data, expected read data}
    localparam logic [69:0] VEC [0:NVEC-1] = '{
        {1'b1, 5'h00, 32'hFEDCBA98, 32'h0},
        {1'b0, 5'h00, 32'h0,        32'h76543210},
        {1'b1, 5'h04, 32'hDEADBEEF, 32'h0},
        {1'b0, 5'h04, 32'h0,        32'hDEADBEEF},
        {1'b1, 5'h08, 32'h000000A5, 32'h0},
        {1'b0, 5'h08, 32'h0,        32'h000000A5},
        {1'b1, 5'h08, 32'h0000FF3C, 32'h0},
        {1'b0, 5'h08, 32'h0,        32'h0000003C},
        {1'b1, 5'h0C, 32'hFFFFFFFF, 32'h0},
        {1'b0, 5'h0C, 32'h0,        32'h0},
        {1'b1, 5'h14, 32'hFFFFFFFF, 32'h0},
        {1'b0, 5'h14, 32'h0,        32'h0},
        {1'b0, 5'h18, 32'h0,        32'h0},
        {1'b0, 5'h10, 32'h0,        32'h0},
        {1'b0, 5'h04, 32'h0,        32'hDEADBEEF},
        {1'b0, 5'h00, 32'h0,        32'h76543210}
    };

    function automatic string tag_for(input logic [4:0] off);
        case (off)
            5'h00:   return "R2";
            5'h04:   return "R3";
            5'h08:   return "R4";
            5'h10:   return "R7";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] off, input logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = off; bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [4:0] off, output logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = off;
        @(negedge clk);
        bus_sel = 1'b0;
        data = bus_rdata;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] held;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 start", {24'b0, ch_start}, 32'h0);
        check("R1 mode", {16'b0, ch_mode}, 32'h0);
        bus_read(5'h00, rd); check("R1 mode word", rd, 32'h0);
        bus_read(5'h08, rd); check("R1 run word", rd, 32'h0);
        bus_read(5'h10, rd); check("R1 status word", rd, 32'h0);

        // table walk
        for (int k = 0; k < NVEC; k++) begin
            if (VEC[k][69]) begin
                bus_write(VEC[k][68:64], VEC[k][63:32]);
            end else begin
                bus_read(VEC[k][68:64], rd);
                check(tag_for(VEC[k][68:64]), rd, VEC[k][31:0]);
            end
        end

        // R2 outputs after the mode write of the table
        check("R2 ch_mode", {16'b0, ch_mode}, 32'h0000E4E4);
        check("R2 ch_dir", {24'b0, ch_dir}, 32'h000000F0);

        // R5 and R6: channel 3 is waiting, channels 0..2 idle
        ch_state = 16'h0080;
        bus_write(5'h08, 32'h00000FFF);
        check("R5 start strobe", {24'b0, ch_start}, 32'h00000007);
        @(negedge clk);
        check("R5 strobe single cycle", {24'b0, ch_start}, 32'h0);
        check("R6 busy channel", {31'b0, ch_start[3]}, 32'h0);

        // R7 live state bits
        ch_state = 16'h1B4E;
        bus_read(5'h10, rd); check("R7 state field", rd, 32'h1B4E0000);

        // R8 done sets irq flag
        @(negedge clk); ch_done = 8'h02;
        @(negedge clk); ch_done = '0;
        bus_read(5'h10, rd); check("R8 done flag", rd, 32'h1B4E0002);
        check("R11 irq with enable", {31'b0, irq}, 32'h1);
        // R8 error sets both
        @(negedge clk); ch_err = 8'h20;
        @(negedge clk); ch_err = '0;
        repeat (3) @(negedge clk);
        bus_read(5'h10, rd); check("R8 error flags sticky", rd, 32'h1B4E2022);

        // R9 write-1-to-clear of channel 1 only
        bus_write(5'h10, 32'h00000002);
        bus_read(5'h10, rd); check("R9 partial clear", rd, 32'h1B4E2020);

        // R11 enable gating
        bus_write(5'h08, 32'h00000000);
        check("R11 disabled", {31'b0, irq}, 32'h0);
        bus_write(5'h08, 32'h00000020);
        check("R11 enabled", {31'b0, irq}, 32'h1);

        // R10 set wins over simultaneous clear
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h10; bus_wdata = 32'h00000004;
        ch_done = 8'h04;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; ch_done = '0;
        bus_read(5'h10, rd); check("R10 set beats clear", rd, 32'h1B4E2024);

        // R9 full clear
        bus_write(5'h10, 32'h0000FFFF);
        check("R9 irq drops", {31'b0, irq}, 32'h0);
        bus_read(5'h10, rd); check("R9 all cleared", rd, 32'h1B4E0000);

        // R13 read data holds across writes and idle cycles
        bus_read(5'h04, held);
        bus_write(5'h04, 32'h12345678);
        repeat (2) @(negedge clk);
        check("R13 rdata held", bus_rdata, held);
        bus_read(5'h04, rd); check("R3 rewritten", rd, 32'h12345678);

        finish_run();
    end

endmodule